// File: doc/BRIEF.md
# DMA Page Address Extender

The block turns the 16-bit offset produced by a DMA address counter into a 24-bit physical memory address. For every channel it keeps an 8-bit page latch that the host loads and reads back through an 8-bit I/O port address. When a channel takes the bus, the block captures that channel's page and channel type. It drives the captured page on the upper address bits, with the live offset below it, for as long as the channel keeps the bus.

Channels 0 to 3 move bytes, so their address is the page followed by the offset. Channels 4 to 7 move 16-bit words. For those the offset is shifted up one bit, so bit 0 of the address is always 0, and bit 0 of the page latch is not used. The page sits outside the counter, so when the offset rolls over from all ones to zero the page does not move. The block raises a one-cycle flag on that rollover so a test can see it. Channel 4 has no page port, so its page is always zero. A spare latch for the refresh page can be read and written but never drives the bus.

Top module: `dma_page_ext`

## Requirements
- R1: After reset every page latch reads 0, `addr_oe_o` is 0, `addr_o` is 0 and `wrap_o` is 0.
- R2: Host writes land on the rising clock edge when `io_wr_i` is 1. The port-to-latch map is: 0x87 is channel 0, 0x83 is channel 1, 0x81 is channel 2, 0x82 is channel 3, 0x8B is channel 5, 0x89 is channel 6, 0x8A is channel 7, and 0x8F is the refresh spare. While `io_rd_i` is 1 at a mapped port, `io_rdata_o` shows that latch in the same cycle.
- R3: A write to any port that is not in the R2 map leaves every latch unchanged. A read of such a port returns 0, and so does any cycle with `io_rd_i` at 0.
- R4: While a byte channel (0 to 3) is active, `addr_o` = {page, offset}, with the page in bits 23:16 and the offset in bits 15:0.
- R5: While a word channel (4 to 7) is active, `addr_o` = {page[7:1], offset, 1'b0}, so address bit 0 is always 0.
- R6: The page and the channel type are taken in the first cycle with `bus_act_i` at 1. From the first cycle of activity onward, host writes and changes on `ch_i` have no effect on the page bits until `bus_act_i` falls. A write made while the channel is active takes effect at the next activation.
- R7: While `bus_act_i` is 0, `addr_oe_o` is 0 and `addr_o` is 0. While it is 1, `addr_oe_o` is 1.
- R8: `wrap_o` is 1 in exactly those active cycles that follow an active cycle, where the previous offset was 0xFFFF and the current offset is 0x0000. In such a cycle the page bits keep their previous value.
- R9: Channel 4 has no page port, so its page is always 0. Its address is {7'b0, offset, 1'b0}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_addr_i | input | 8 | Host I/O port address |
| io_wr_i | input | 1 | Host write strobe |
| io_rd_i | input | 1 | Host read strobe |
| io_wdata_i | input | 8 | Host write data |
| io_rdata_o | output | 8 | Host read data |
| ch_i | input | 3 | Number of the channel that owns the bus |
| bus_act_i | input | 1 | A channel owns the bus |
| ofs_i | input | 16 | Offset from the address counter |
| addr_o | output | 24 | Physical address |
| addr_oe_o | output | 1 | Upper address drive enable |
| wrap_o | output | 1 | Offset rolled over from 0xFFFF to 0x0000 |

## Verification
Byte channels, word channels and channel 4 are each activated with a distinct page in every latch. This exposes a wrong latch select, a missing word shift or a stray latch behind channel 4. Host writes to a channel's own port while it is active, followed by a later reactivation, separate a page held for the whole activation from one that follows the latch. Offset sequences that step from 0xFFFF to 0x0000, and ones that jump to 0 from other values, show whether the rollover flag and the page are free of any carry. Random mixes of writes to mapped and unmapped ports, reads and bursts check the port decode against a model of the latch map.

// File: rtl/dma_page_pkg.sv
package dma_page_pkg;
  localparam int IO_AW    = 8;
  localparam int NUM_CH   = 8;
  localparam int NUM_SLOT = NUM_CH + 1;
  localparam int SLOT_W   = $clog2(NUM_SLOT);
  localparam int CH_W     = $clog2(NUM_CH);

  typedef struct packed {
    logic              hit;
    logic [SLOT_W-1:0] slot;
  } port_map_t;

  // slot index equals channel number; slot NUM_CH is the refresh spare
  function automatic port_map_t map_port(input logic [IO_AW-1:0] a);
    port_map_t m;
    m.hit = 1'b1;
    case (a)
      8'h87:   m.slot = SLOT_W'(0);
      8'h83:   m.slot = SLOT_W'(1);
      8'h81:   m.slot = SLOT_W'(2);
      8'h82:   m.slot = SLOT_W'(3);
      8'h8B:   m.slot = SLOT_W'(5);
      8'h89:   m.slot = SLOT_W'(6);
      8'h8A:   m.slot = SLOT_W'(7);
      8'h8F:   m.slot = SLOT_W'(NUM_CH);
      default: begin m.hit = 1'b0; m.slot = '0; end
    endcase
    return m;
  endfunction
endpackage

// File: rtl/dma_page_regs.sv
module dma_page_regs
  import dma_page_pkg::*;
#(
  parameter int PAGE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IO_AW-1:0]  io_addr_i,
  input  logic              io_wr_i,
  input  logic              io_rd_i,
  input  logic [PAGE_W-1:0] io_wdata_i,
  output logic [PAGE_W-1:0] io_rdata_o,
  input  logic [CH_W-1:0]   ch_i,
  output logic [PAGE_W-1:0] ch_page_o
);
  port_map_t map;
  logic [PAGE_W-1:0] pages_q [NUM_SLOT];
  logic [NUM_SLOT*PAGE_W-1:0] pages_flat;

  assign map = map_port(io_addr_i);

  for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pages_q[s] <= '0;
      else if (io_wr_i && map.hit && map.slot == SLOT_W'(s)) pages_q[s] <= io_wdata_i;
    end
    assign pages_flat[s*PAGE_W +: PAGE_W] = pages_q[s];
  end

  assign io_rdata_o = (io_rd_i && map.hit) ? pages_q[map.slot] : '0;
  assign ch_page_o  = pages_q[SLOT_W'(ch_i)];

  assert_unmapped_wr_ignored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_wr_i && !map.hit) |=> $stable(pages_flat));

  assert_unmapped_rd_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !map.hit |-> io_rdata_o == '0);
endmodule

// File: rtl/dma_page_hold.sv
module dma_page_hold
  import dma_page_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int OFS_W  = 16,
  localparam int AW    = PAGE_W + OFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_act_i,
  input  logic [CH_W-1:0]   ch_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic [PAGE_W-1:0] ch_page_i,
  output logic [AW-1:0]     addr_o,
  output logic              addr_oe_o,
  output logic              wrap_o
);
  logic              act_q, snap_word_q;
  logic [PAGE_W-1:0] snap_page_q;
  logic [OFS_W-1:0]  ofs_q;
  logic              start, word_now, cur_word;
  logic [PAGE_W-1:0] cur_page;

  assign start    = bus_act_i && !act_q;
  assign word_now = ch_i >= CH_W'(NUM_CH / 2);
  assign cur_page = start ? ch_page_i : snap_page_q;
  assign cur_word = start ? word_now  : snap_word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q       <= 1'b0;
      snap_word_q <= 1'b0;
      snap_page_q <= '0;
      ofs_q       <= '0;
    end else begin
      act_q <= bus_act_i;
      ofs_q <= ofs_i;
      if (start) begin
        snap_page_q <= ch_page_i;
        snap_word_q <= word_now;
      end
    end
  end

  always_comb begin
    if (!bus_act_i)    addr_o = '0;
    else if (cur_word) addr_o = {cur_page[PAGE_W-1:1], ofs_i, 1'b0};
    else               addr_o = {cur_page, ofs_i};
  end

  assign addr_oe_o = bus_act_i;
  // counter rolled over; page stays put
  assign wrap_o = bus_act_i && act_q && (&ofs_q) && !(|ofs_i);

  assert_page_held_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && bus_act_i) |-> addr_o[AW-1:OFS_W+1] == $past(addr_o[AW-1:OFS_W+1]));

  assert_wrap_no_carry_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_o && !cur_word) |-> addr_o[OFS_W] == $past(addr_o[OFS_W]));

  assert_idle_addr_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_oe_o |-> addr_o == '0);

  assert_word_a0_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_oe_o && cur_word) |-> !addr_o[0]);
endmodule

// File: rtl/dma_page_ext.sv
module dma_page_ext
  import dma_page_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int OFS_W  = 16,
  localparam int AW    = PAGE_W + OFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IO_AW-1:0]  io_addr_i,
  input  logic              io_wr_i,
  input  logic              io_rd_i,
  input  logic [PAGE_W-1:0] io_wdata_i,
  output logic [PAGE_W-1:0] io_rdata_o,
  input  logic [CH_W-1:0]   ch_i,
  input  logic              bus_act_i,
  input  logic [OFS_W-1:0]  ofs_i,
  output logic [AW-1:0]     addr_o,
  output logic              addr_oe_o,
  output logic              wrap_o
);
  logic [PAGE_W-1:0] ch_page;

  dma_page_regs #(.PAGE_W(PAGE_W)) u_regs (
    .clk_i, .rst_ni, .io_addr_i, .io_wr_i, .io_rd_i, .io_wdata_i, .io_rdata_o,
    .ch_i, .ch_page_o(ch_page)
  );

  dma_page_hold #(.PAGE_W(PAGE_W), .OFS_W(OFS_W)) u_hold (
    .clk_i, .rst_ni, .bus_act_i, .ch_i, .ofs_i, .ch_page_i(ch_page),
    .addr_o, .addr_oe_o, .wrap_o
  );

  assert_reset_state_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !wrap_o);
endmodule

// File: tb/dma_page_ext_test.sv
module dma_page_ext_test;
  localparam int CLK_PER = 10;
  localparam int Q = CLK_PER / 4;

  logic        clk = 0, rst_ni = 0;
  logic [7:0]  io_addr = 0, io_wdata = 0;
  logic        io_wr = 0, io_rd = 0, bus_act = 0;
  logic [2:0]  ch = 0;
  logic [15:0] ofs = 0;
  logic [7:0]  io_rdata;
  logic [23:0] addr;
  logic        addr_oe, wrap;

  int n_run = 0, n_fail = 0;
  logic [7:0]  model [9];
  logic        prev_act = 0;
  logic [15:0] prev_ofs = 0;
  logic [7:0]  cap_page = 0;
  logic        cap_word = 0;

  always #(CLK_PER/2) clk = ~clk;

  dma_page_ext uut (
    .clk_i(clk), .rst_ni(rst_ni), .io_addr_i(io_addr), .io_wr_i(io_wr), .io_rd_i(io_rd),
    .io_wdata_i(io_wdata), .io_rdata_o(io_rdata), .ch_i(ch), .bus_act_i(bus_act),
    .ofs_i(ofs), .addr_o(addr), .addr_oe_o(addr_oe), .wrap_o(wrap)
  );

  function automatic int port_slot(input logic [7:0] a);
    case (a)
      8'h87: return 0; 8'h83: return 1; 8'h81: return 2; 8'h82: return 3;
      8'h8B: return 5; 8'h89: return 6; 8'h8A: return 7; 8'h8F: return 8;
      default: return -1;
    endcase
  endfunction

  function automatic logic [7:0] chan_port(input int c);
    case (c)
      0: return 8'h87; 1: return 8'h83; 2: return 8'h81; 3: return 8'h82;
      5: return 8'h8B; 6: return 8'h89; default: return 8'h8A;
    endcase
  endfunction

  function automatic logic [23:0] exp_addr(input logic [7:0] pg, input logic wd, input logic [15:0] o);
    return wd ? {pg[7:1], o, 1'b0} : {pg, o};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check before next posedge, commit model
  task automatic step(input string tag, input logic act, input int c, input logic [15:0] o,
                      input logic wr, input logic [7:0] wa, input logic [7:0] wd);
    logic [23:0] ea;
    logic ew;
    @(negedge clk);
    bus_act = act; ch = 3'(c); ofs = o; io_wr = wr; io_addr = wa; io_wdata = wd;
    if (act && !prev_act) begin
      cap_page = model[c];
      cap_word = (c >= 4);
    end
    ea = act ? exp_addr(cap_page, cap_word, o) : 24'h0;
    ew = act && prev_act && prev_ofs == 16'hFFFF && o == 16'h0;
    #Q;
    chk(tag, {7'b0, addr_oe, addr}, {7'b0, act, ea});
    chk({tag, "_wrap"}, {31'b0, wrap}, {31'b0, ew});
    if (wr && port_slot(wa) >= 0) model[port_slot(wa)] = wd;
    prev_act = act; prev_ofs = o;
  endtask

  task automatic wr_port(input string tag, input logic [7:0] a, input logic [7:0] d);
    step(tag, 1'b0, 0, 16'h0, 1'b1, a, d);
  endtask

  task automatic rd_port(input string tag, input logic [7:0] a);
    @(negedge clk);
    io_wr = 0; io_rd = 1; io_addr = a;
    #Q;
    chk(tag, {24'b0, io_rdata}, {24'b0, (port_slot(a) >= 0) ? model[port_slot(a)] : 8'h0});
    @(negedge clk);
    io_rd = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] unm [5] = '{8'h80, 8'h84, 8'h88, 8'h8C, 8'h00};
    void'($urandom(32'h1234abcd));
    for (int i = 0; i < 9; i++) model[i] = 8'h0;
    #(CLK_PER*2 + Q);
    chk("R1_oe", {31'b0, addr_oe}, 32'h0);
    chk("R1_addr", {8'b0, addr}, 32'h0);
    chk("R1_wrap", {31'b0, wrap}, 32'h0);
    @(negedge clk); rst_ni = 1;
    for (int i = 0; i < 9; i++) if (i != 4) rd_port("R1_latch", (i == 8) ? 8'h8F : chan_port(i));

    // R2: distinct page in every latch
    for (int i = 0; i < 8; i++) if (i != 4) wr_port("R2_wr", chan_port(i), 8'h11 * 8'(i + 1));
    wr_port("R2_wr", 8'h8F, 8'hE7);
    for (int i = 0; i < 8; i++) if (i != 4) rd_port("R2_rd", chan_port(i));
    rd_port("R2_rd_refresh", 8'h8F);

    // R3: unmapped ports
    foreach (unm[i]) wr_port("R3_wr", unm[i], 8'h5A);
    foreach (unm[i]) rd_port("R3_rd_unmapped", unm[i]);
    for (int i = 0; i < 8; i++) if (i != 4) rd_port("R3_rd_kept", chan_port(i));

    // R4 byte, R5 word, R9 channel 4
    step("R4_byte", 1, 2, 16'h3456, 0, 0, 0);
    step("R4_byte", 1, 2, 16'h3457, 0, 0, 0);
    step("R7_idle", 0, 2, 16'h3458, 0, 0, 0);
    step("R5_word", 1, 6, 16'h9ABC, 0, 0, 0);
    step("R7_idle", 0, 0, 16'h0, 0, 0, 0);
    step("R9_ch4", 1, 4, 16'h8001, 0, 0, 0);
    step("R7_idle", 0, 0, 16'h0, 0, 0, 0);

    // R6: write and channel change while active
    step("R6_start", 1, 1, 16'h0100, 0, 0, 0);
    step("R6_hold_wr", 1, 1, 16'h0101, 1, 8'h83, 8'hC3);
    step("R6_hold", 1, 1, 16'h0102, 0, 0, 0);
    step("R6_hold_ch", 1, 7, 16'h0103, 0, 0, 0);
    step("R7_idle", 0, 1, 16'h0, 0, 0, 0);
    step("R6_next", 1, 1, 16'h0200, 0, 0, 0);
    step("R7_idle", 0, 1, 16'h0, 0, 0, 0);

    // R8: rollover, byte and word
    wr_port("R8_setup", 8'h82, 8'hFF);
    step("R8_pre", 1, 3, 16'hFFFF, 0, 0, 0);
    step("R8_wrap", 1, 3, 16'h0000, 0, 0, 0);
    step("R8_after", 1, 3, 16'h0001, 0, 0, 0);
    step("R8_nojump", 1, 3, 16'h0000, 0, 0, 0);
    step("R7_idle", 0, 3, 16'hFFFF, 0, 0, 0);
    step("R8_fresh", 1, 5, 16'h0000, 0, 0, 0);
    step("R8_pre_w", 1, 5, 16'hFFFF, 0, 0, 0);
    step("R8_wrap_w", 1, 5, 16'h0000, 0, 0, 0);
    step("R7_idle", 0, 0, 16'h0, 0, 0, 0);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op = int'($urandom_range(0, 3));
      if (op == 0) begin
        logic [7:0] a = ($urandom_range(0, 1) == 1) ? 8'($urandom) : chan_port(int'($urandom_range(0, 7)));
        wr_port("R2_R3_rand_wr", a, 8'($urandom));
      end else if (op == 1) begin
        logic [7:0] a = ($urandom_range(0, 1) == 1) ? 8'($urandom) : 8'h80 + 8'($urandom_range(0, 15));
        rd_port("R2_R3_rand_rd", a);
      end else begin
        int c = int'($urandom_range(0, 7));
        int len = int'($urandom_range(1, 6));
        logic [15:0] o = ($urandom_range(0, 3) == 0) ? 16'hFFFE : 16'($urandom);
        for (int k = 0; k < len; k++) begin
          logic w = ($urandom_range(0, 3) == 0);
          step((c >= 4) ? "R5_R6_rand" : "R4_R6_rand", 1, c, o, w, chan_port(c), 8'($urandom));
          o = o + 16'd1;
        end
        step("R7_rand_idle", 0, c, o, 0, 0, 0);
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule